// File: doc/BRIEF.md
# Pulse-Count-Validated Serial Command Port

This block is the serial front end of an eight-channel switch array. It runs in the system clock domain and takes already-synchronized copies of the serial clock, the active-low chip select and the data-in line. It detects their edges, shifts a command in on each rising serial clock and drives a status word out on each falling serial clock, most significant bit first. When chip select falls, the block captures the eight fault flags and prepares a 16-bit reply: eight zero bits, then the flags.

The block counts serial clock pulses in every frame. When chip select rises, the frame is accepted only if the count is 16, 24, 32 and so on. On acceptance, the low byte of the last 16 bits received is loaded into the output register and a one-cycle latch strobe is raised. Any other count leaves the outputs untouched. Frames longer than 16 bits pass earlier input back out on the data-out line, which supports daisy chains and a loop-back integrity check. The pulse counter saturates, so an overlong frame is refused instead of wrapping around.

Top module: `pcv_spi_slave`

## Requirements
- R1: A frame of exactly 16 serial clock pulses is accepted. One clock after the rising chip select is seen, `out_o` holds the low 8 bits of the 16 bits shifted in.
- R2: Data-out sends MSB first. Bit 0 of the reply is valid after chip select falls, and each later bit follows a falling serial clock. The first 8 reply bits are 0, and the next 8 are `status_i[7]` down to `status_i[0]`, as sampled when chip select fell.
- R3: A frame of 16 + 8k pulses (k ≥ 1) is accepted. `out_o` then takes the last 8 bits shifted in.
- R4: Any other pulse count, zero included, is ignored. `out_o` keeps its value and no latch strobe is raised.
- R5: After the 16 reply bits, data-out returns the bits received in the same frame, in the order they arrived.
- R6: The pulse counter stops at 2^CNT_W − 1 (255 by default). A frame of that many pulses or more is refused even if its length has the legal form. 248 pulses is still accepted.
- R7: The upper 8 bits of the 16-bit command word have no effect on `out_o`.
- R8: `miso_oe_o` is 0 while chip select is high and 1 while it is low, with one clock of delay. The pad must leave data-out undriven when this enable is 0.
- R9: `sof_o` is a one-cycle pulse, issued one clock after chip select falls.
- R10: `latch_stb_o` is a one-cycle pulse raised once for each accepted frame, in the same cycle that `out_o` takes its new value.
- R11: After reset, `out_o` is 0, `miso_oe_o` is 0, and neither strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Synchronized serial clock, idle low |
| csn_i | input | 1 | Synchronized chip select, active low |
| mosi_i | input | 1 | Synchronized serial data in |
| status_i | input | 8 | Fault flags captured at frame start |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for the data-out pad |
| out_o | output | 8 | Latched switch commands |
| latch_stb_o | output | 1 | One-cycle strobe on an accepted frame |
| sof_o | output | 1 | One-cycle strobe at frame start |

## Verification
The assertions assume the following about the inputs:
- Each serial clock level is held for at least two system clocks.
- The serial clock is low whenever chip select changes.
- No serial clock edge lands in the same system cycle as a chip select edge.
- `csn_i` is high during reset.

The stimulus keeps each serial clock phase for two to three system clocks. It changes data-in only while the serial clock is low. It waits several cycles around every chip select edge. Frame lengths cover legal, illegal, empty and saturating cases, and the bench checks every output against a behavioural model on every clock.

// File: rtl/sw_spi_pkg.sv
package sw_spi_pkg;

  // Legal frame: at least base pulses, a whole number of steps beyond it,
  // and strictly below the saturation value of the counter.
  function automatic logic count_ok(input int unsigned n,
                                    input int unsigned base,
                                    input int unsigned step,
                                    input int unsigned lim);
    return (n >= base) && (((n - base) % step) == 0) && (n < lim);
  endfunction

endpackage

// File: rtl/sw_pin_edges.sv
module sw_pin_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sel_o
);
  logic sclk_q, csn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      csn_q  <= csn_i;
    end
  end

  // Serial clock edges only count while the device is selected.
  assign sclk_rise_o = sclk_i & ~sclk_q & ~csn_i;
  assign sclk_fall_o = ~sclk_i & sclk_q & ~csn_i;
  assign cs_fall_o   = ~csn_i & csn_q;
  assign cs_rise_o   = csn_i & ~csn_q;
  assign sel_o       = ~csn_q;
endmodule

// File: rtl/sw_pulse_counter.sv
module sw_pulse_counter #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned BASE  = 16,
  parameter int unsigned STEP  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             legal_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clear_i)                   cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign legal_o = sw_spi_pkg::count_ok(32'(cnt_q), BASE, STEP, 32'(CNT_MAX));
endmodule

// File: rtl/sw_shift_chain.sv
module sw_shift_chain #(
  parameter int unsigned W     = 16,
  parameter int unsigned TAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     load_val_i,
  input  logic             shift_i,
  input  logic             din_i,
  input  logic             adv_i,
  output logic [TAP_W-1:0] tap_o,
  output logic             sdo_o
);
  logic [W-1:0] sr_q;
  logic         sdo_q;

  // One chain serves both directions: bits leaving the top after the
  // reply word are the earliest bits received, which gives the echo.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      sr_q  <= load_val_i;
      sdo_q <= load_val_i[W-1];
    end else begin
      if (shift_i) sr_q  <= {sr_q[W-2:0], din_i};
      if (adv_i)   sdo_q <= sr_q[W-1];
    end
  end

  assign tap_o = sr_q[TAP_W-1:0];
  assign sdo_o = sdo_q;
endmodule

// File: rtl/pcv_spi_slave.sv
module pcv_spi_slave #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned OUT_W   = 8,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  input  logic [OUT_W-1:0] status_i,
  output logic             miso_o,
  output logic             miso_oe_o,
  output logic [OUT_W-1:0] out_o,
  output logic             latch_stb_o,
  output logic             sof_o
);
  localparam int unsigned PAD_W = FRAME_W - OUT_W;

  // Named internal events, also observed by the bound checker.
  logic             sclk_rise_w, sclk_fall_w, cs_fall_w, cs_rise_w, sel_w;
  logic [CNT_W-1:0] cnt_w;
  logic             legal_w, accept_w;
  logic [OUT_W-1:0] cmd_low_w;
  logic [FRAME_W-1:0] reply_w;

  logic [OUT_W-1:0] out_q;
  logic             stb_q, sof_q;

  assign reply_w = {{PAD_W{1'b0}}, status_i};

  sw_pin_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_i),
    .csn_i      (csn_i),
    .sclk_rise_o(sclk_rise_w),
    .sclk_fall_o(sclk_fall_w),
    .cs_fall_o  (cs_fall_w),
    .cs_rise_o  (cs_rise_w),
    .sel_o      (sel_w)
  );

  sw_pulse_counter #(.CNT_W(CNT_W), .BASE(FRAME_W), .STEP(OUT_W)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(cs_fall_w),
    .inc_i  (sclk_rise_w),
    .cnt_o  (cnt_w),
    .legal_o(legal_w)
  );

  sw_shift_chain #(.W(FRAME_W), .TAP_W(OUT_W)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cs_fall_w),
    .load_val_i(reply_w),
    .shift_i   (sclk_rise_w),
    .din_i     (mosi_i),
    .adv_i     (sclk_fall_w),
    .tap_o     (cmd_low_w),
    .sdo_o     (miso_o)
  );

  assign accept_w = cs_rise_w & legal_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      stb_q <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      stb_q <= accept_w;
      sof_q <= cs_fall_w;
      if (accept_w) out_q <= cmd_low_w;
    end
  end

  assign out_o       = out_q;
  assign latch_stb_o = stb_q;
  assign sof_o       = sof_q;
  assign miso_oe_o   = sel_w;
endmodule

// File: rtl/sw_spi_checks.sv
module sw_spi_checks #(
  parameter int unsigned OUT_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csn_i,
  input logic [OUT_W-1:0] out_o,
  input logic             latch_stb_o,
  input logic             sof_o,
  input logic             miso_oe_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic             cs_fall_w
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_stb_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_stb_o |=> !latch_stb_o);

  p_out_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_stb_o |-> $stable(out_o));

  p_oe_follows_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (miso_oe_o == !$past(csn_i)));

  p_sof_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  p_sof_selected_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> miso_oe_o);

  p_stb_deselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_stb_o |-> !miso_oe_o);

  p_cnt_saturate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == CNT_MAX && !cs_fall_w) |=> (cnt_w == CNT_MAX));
endmodule

bind pcv_spi_slave sw_spi_checks #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .csn_i      (csn_i),
  .out_o      (out_o),
  .latch_stb_o(latch_stb_o),
  .sof_o      (sof_o),
  .miso_oe_o  (miso_oe_o),
  .cnt_w      (cnt_w),
  .cs_fall_w  (cs_fall_w)
);

// File: tb/sim_pcv_spi_slave.sv
module sim_pcv_spi_slave;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, sclk, csn, mosi;
  logic [7:0] status;
  logic       miso, miso_oe, stb, sof;
  logic [7:0] outv;

  pcv_spi_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .status_i(status), .miso_o(miso), .miso_oe_o(miso_oe), .out_o(outv),
    .latch_stb_o(stb), .sof_o(sof)
  );

  int n_cmp = 0, n_bad = 0;
  int stb_n = 0, sof_n = 0, frames = 0;
  bit seq[$];
  bit got[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   txq[$], rxq[$];
  int   m_cnt;
  bit   m_psclk, m_pcsn;
  logic [7:0] e_out;
  bit   e_stb, e_sof, e_oe, e_miso;

  always @(posedge clk) begin : model
    bit rise, fall, cf, cr;
    if (!rst_n) begin
      m_psclk = 0; m_pcsn = 1; m_cnt = 0; e_out = 8'h00;
      e_stb = 0; e_sof = 0; e_oe = 0; e_miso = 0;
      txq.delete(); rxq.delete();
    end else begin
      cf   = !csn && m_pcsn;
      cr   = csn && !m_pcsn;
      rise = sclk && !m_psclk && !csn;
      fall = !sclk && m_psclk && !csn;
      e_stb = 0;
      e_sof = cf;
      e_oe  = !csn;
      if (cf) begin
        txq.delete(); rxq.delete(); m_cnt = 0;
        for (int k = 0; k < 8; k++) txq.push_back(1'b0);
        for (int k = 7; k >= 0; k--) txq.push_back(status[k]);
        e_miso = txq.pop_front();
      end else begin
        if (rise) begin
          rxq.push_back(mosi);
          txq.push_back(mosi);
          if (m_cnt < 255) m_cnt++;
        end
        if (fall && txq.size() > 0) e_miso = txq.pop_front();
      end
      if (cr && m_cnt >= 16 && (m_cnt - 16) % 8 == 0 && m_cnt < 255) begin
        for (int k = 0; k < 8; k++) e_out[7-k] = rxq[rxq.size()-8+k];
        e_stb = 1;
      end
      m_psclk = sclk;
      m_pcsn  = csn;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1/R3", "out_o vs model", outv, e_out);
      chk("R10", "latch_stb_o vs model", stb, e_stb);
      chk("R9", "sof_o vs model", sof, e_sof);
      chk("R8", "miso_oe_o vs model", miso_oe, e_oe);
      if (e_oe) chk("R2/R5", "miso_o vs model", miso, e_miso);
      if (stb) stb_n++;
      if (sof) sof_n++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) seq.push_back(v[i]);
  endtask

  task automatic pad_bits(input int n);
    for (int i = 0; i < n; i++) seq.push_back(i[1] ^ i[0]);
  endtask

  task automatic run_frame();
    got.delete();
    csn = 1'b0;
    idle(3);
    chk("R8", "enable during frame", miso_oe, 1);
    foreach (seq[i]) begin
      mosi = seq[i];
      idle(2);
      got.push_back(miso);
      sclk = 1'b1;
      idle(3);
      sclk = 1'b0;
    end
    idle(2);
    csn = 1'b1;
    mosi = 1'b0;
    idle(4);
    chk("R8", "enable after frame", miso_oe, 0);
    seq.delete();
    frames++;
  endtask

  function automatic int got_bits(input int from, input int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = (v << 1) | int'(got[from+i]);
    return v;
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int s0;
    int lens[7] = '{0, 8, 15, 17, 23, 31, 33};
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; mosi = 1'b0; status = 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(2);
    chk("R11", "reset out_o", outv, 0);
    chk("R11", "reset miso_oe_o", miso_oe, 0);
    chk("R11", "reset latch_stb_o", stb, 0);
    chk("R11", "reset sof_o", sof, 0);

    // R1 / R2: basic 16-pulse frame
    status = 8'h3C; s0 = stb_n;
    load_bits(64'hA55A, 16); run_frame();
    chk("R1", "out after 16-pulse frame", outv, 8'h5A);
    chk("R2", "reply leading zeros", got_bits(0, 8), 0);
    chk("R2", "reply status byte", got_bits(8, 8), 8'h3C);
    chk("R10", "one strobe per accepted frame", stb_n - s0, 1);

    // R7: upper command byte has no effect
    load_bits(64'h0081, 16); run_frame();
    chk("R7", "out after 0x0081", outv, 8'h81);
    s0 = stb_n;
    load_bits(64'hFF81, 16); run_frame();
    chk("R7", "out after 0xFF81", outv, 8'h81);
    chk("R10", "strobe for accepted frame", stb_n - s0, 1);

    // R3: 24-pulse frame
    status = 8'hA5;
    load_bits(64'hABCDEF, 24); run_frame();
    chk("R3", "out after 24-pulse frame", outv, 8'hEF);
    chk("R2", "reply status byte 0xA5", got_bits(8, 8), 8'hA5);

    // R5: 32-pulse frame echoes first 16 bits
    status = 8'h00;
    load_bits(64'h12345678, 32); run_frame();
    chk("R3", "out after 32-pulse frame", outv, 8'h78);
    chk("R5", "echo of first half", got_bits(16, 16), 16'h1234);

    // R4: illegal lengths leave outputs alone
    foreach (lens[j]) begin
      s0 = stb_n;
      load_bits(64'hFFFF_FFFF_FFFF_FF66, lens[j]); run_frame();
      chk("R4", $sformatf("out after %0d pulses", lens[j]), outv, 8'h78);
      chk("R4", $sformatf("strobes after %0d pulses", lens[j]), stb_n - s0, 0);
    end

    // R3: 40-pulse frame
    load_bits(64'h11_2233_4455, 40); run_frame();
    chk("R3", "out after 40-pulse frame", outv, 8'h55);

    // R6: largest legal length below saturation, then one beyond it
    s0 = stb_n;
    pad_bits(232); load_bits(64'h0099, 16); run_frame();
    chk("R6", "out after 248-pulse frame", outv, 8'h99);
    chk("R6", "strobe after 248-pulse frame", stb_n - s0, 1);
    s0 = stb_n;
    pad_bits(248); load_bits(64'h00EE, 16); run_frame();
    chk("R6", "out after 264-pulse frame", outv, 8'h99);
    chk("R6", "strobes after 264-pulse frame", stb_n - s0, 0);

    chk("R9", "start pulses equal frames", sof_n, frames);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule